// File: doc/BRIEF.md
# Split-Access Configuration Register Bank

This block holds two 64-bit configuration registers for an address translation unit: a control word and a table-base word. A processor reaches them through a small memory-mapped slave port. Each request lasts a single cycle and carries an address, a size flag (64-bit or 32-bit), a write enable and write data. Read data is registered and appears one cycle after the request. Both registers also drive plain outputs that the translation walker reads at any time.

A 32-bit access lets software with a narrow data path update or inspect one half of a register and leave the other half unchanged. The lower address of each register holds the most significant half, so the layout is big-endian. A pair of 32-bit slots above the two registers accepts writes and discards them. Every other offset is treated as empty.

Top module: `cfg_regbank`

## Requirements
- R1: While reset is asserted and after it is released, ctrl_o, base_o and rdata_o are all zero.
- R2: A 64-bit write (size64_i=1) at offset 0x00 replaces all of ctrl_o with wdata_i, and one at 0x08 replaces all of base_o. The new value appears the cycle after the request.
- R3: A 32-bit write (size64_i=0) at offset 0x00 (control) or 0x08 (base) loads wdata_i[31:0] into bits 63:32 of that register and leaves bits 31:0 unchanged.
- R4: A 32-bit write at offset 0x04 (control) or 0x0C (base) loads wdata_i[31:0] into bits 31:0 of that register and leaves bits 63:32 unchanged.
- R5: A 64-bit read at offset 0x00 or 0x08 returns the whole register on rdata_o in the cycle after the request.
- R6: A 32-bit read returns one half in rdata_o[31:0], with rdata_o[63:32] zero. Offset 0x00 or 0x08 gives bits 63:32 of the register, and 0x04 or 0x0C gives bits 31:0.
- R7: Writes to offset 0x10 or 0x14 change neither register, and reads from those offsets return zero.
- R8: An access that does not map ignores writes and reads as zero. This covers offsets 0x18 to 0x1F, a 32-bit access with addr_i[1:0] not zero, and a 64-bit access with addr_i[2:0] not zero.
- R9: In the cycle after a cycle with no read request (req_i=0, or a write), rdata_o is zero.
- R10: Neither register changes in a cycle without a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset into the bank |
| size64_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| wdata_i | input | 64 | Write data. A 32-bit access uses bits 31:0 |
| rdata_o | output | 64 | Registered read data, valid the cycle after a read |
| ctrl_o | output | 64 | Current control register |
| base_o | output | 64 | Current table-base register |

## Verification
The hardest case to reach is a register whose two halves were last written by different paths. For example, a 64-bit write is followed by a 32-bit write to one half, and then both halves are read back with 32-bit reads and with a 64-bit read. Stimulus that stays at one access size never shows that a half-write disturbed its neighbour. The directed sequence therefore alternates sizes on the same register with distinct data patterns in each half. A long random phase follows, mixing sizes, offsets (including misaligned and empty ones) and idle cycles. On every clock a behavioural model predicts the value of all three outputs.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned NREG   = 2;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'd0,
    TGT_BASE  = 2'd1,
    TGT_FLUSH = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic sel_hi;
    logic sel_lo;
  } dec_t;
endpackage

// File: rtl/cfg_regbank_decode.sv
module cfg_regbank_decode
  import cfg_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size64_i,
  output dec_t              dec_o
);
  logic aligned;

  always_comb begin
    aligned = size64_i ? (addr_i[2:0] == 3'b000) : (addr_i[1:0] == 2'b00);
    dec_o.tgt    = TGT_NONE;
    dec_o.sel_hi = 1'b0;
    dec_o.sel_lo = 1'b0;
    if (aligned) begin
      unique case (addr_i[4:3])
        2'd0:    dec_o.tgt = TGT_CTRL;
        2'd1:    dec_o.tgt = TGT_BASE;
        2'd2:    dec_o.tgt = TGT_FLUSH;
        default: dec_o.tgt = TGT_NONE;
      endcase
      // big-endian: lower offset holds the upper half
      dec_o.sel_hi = size64_i | ~addr_i[2];
      dec_o.sel_lo = size64_i |  addr_i[2];
    end
  end
endmodule

// File: rtl/cfg_regbank_reg.sv
module cfg_regbank_reg
  import cfg_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [HALF_W-1:0] d_hi_i,
  input  logic [HALF_W-1:0] d_lo_i,
  output logic [DATA_W-1:0] q_o
);
  logic [HALF_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (wr_hi_i) hi_q <= d_hi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= '0;
    else if (wr_lo_i) lo_q <= d_lo_i;
  end

  assign q_o = {hi_q, lo_q};
endmodule

// File: rtl/cfg_regbank_rdmux.sv
module cfg_regbank_rdmux
  import cfg_regbank_pkg::*;
(
  input  dec_t                        dec_i,
  input  logic [NREG-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]           data_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (dec_i.tgt == TGT_CTRL)      sel = regs_i[0];
    else if (dec_i.tgt == TGT_BASE) sel = regs_i[1];
    unique case ({dec_i.sel_hi, dec_i.sel_lo})
      2'b11:   data_o = sel;
      2'b10:   data_o = {{HALF_W{1'b0}}, sel[DATA_W-1:HALF_W]};
      2'b01:   data_o = {{HALF_W{1'b0}}, sel[HALF_W-1:0]};
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size64_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] base_o
);
  dec_t                        dec;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           rd_next;
  logic [HALF_W-1:0]           d_hi;
  logic                        wr;

  cfg_regbank_decode u_dec (
    .addr_i  (addr_i),
    .size64_i(size64_i),
    .dec_o   (dec)
  );

  assign wr   = req_i & we_i;
  assign d_hi = size64_i ? wdata_i[DATA_W-1:HALF_W] : wdata_i[HALF_W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = (dec.tgt == tgt_e'(g));
    cfg_regbank_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_hi_i(wr & hit & dec.sel_hi),
      .wr_lo_i(wr & hit & dec.sel_lo),
      .d_hi_i (d_hi),
      .d_lo_i (wdata_i[HALF_W-1:0]),
      .q_o    (regs[g])
    );
  end

  cfg_regbank_rdmux u_rd (
    .dec_i (dec),
    .regs_i(regs),
    .data_o(rd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_next;
    else                      rdata_o <= '0;
  end

  assign ctrl_o = regs[0];
  assign base_o = regs[1];
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [4:0]  addr_i,
  input logic        size64_i,
  input logic [63:0] wdata_i,
  input logic [63:0] rdata_o,
  input logic [63:0] ctrl_o,
  input logic [63:0] base_o
);
  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (ctrl_o == '0 && base_o == '0 && rdata_o == '0));

  assert_full_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size64_i && addr_i == 5'h08) |=> base_o == $past(wdata_i));

  assert_upper_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !size64_i && addr_i == 5'h00) |=>
      (ctrl_o[63:32] == $past(wdata_i[31:0]) && ctrl_o[31:0] == $past(ctrl_o[31:0])));

  assert_lower_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !size64_i && addr_i == 5'h0C) |=>
      (base_o[31:0] == $past(wdata_i[31:0]) && base_o[63:32] == $past(base_o[63:32])));

  assert_half_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !size64_i) |=> rdata_o[63:32] == '0);

  assert_flush_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[4:3] == 2'b10) |=>
      ($stable(ctrl_o) && $stable(base_o) && rdata_o == '0));

  assert_idle_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(ctrl_o) && $stable(base_o)));
endmodule

bind cfg_regbank cfg_regbank_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .size64_i(size64_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .ctrl_o  (ctrl_o),
  .base_o  (base_o)
);

// File: tb/test_cfg_regbank.sv
module test_cfg_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, size64_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o, ctrl_o, base_o;

  int checks = 0, errors = 0;
  logic [63:0] m_ctrl = '0, m_base = '0, m_rd = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfg_regbank i_cfg_regbank (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .size64_i(size64_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ctrl_o(ctrl_o), .base_o(base_o)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural model of one access
  task automatic model(bit rq, bit w, logic [4:0] a, bit s64, logic [63:0] d);
    logic [63:0] cur;
    int idx;
    bit ok;
    m_rd = '0;
    ok  = s64 ? (a % 8 == 0) : (a % 4 == 0);
    idx = -1;
    if (ok && a < 8) idx = 0;
    else if (ok && a >= 8 && a < 16) idx = 1;
    if (!rq) return;
    cur = (idx == 0) ? m_ctrl : (idx == 1) ? m_base : 64'h0;
    if (w) begin
      if (idx >= 0) begin
        if (s64) cur = d;
        else if (a % 8 == 0) cur = {d[31:0], cur[31:0]};
        else cur = {cur[63:32], d[31:0]};
        if (idx == 0) m_ctrl = cur; else m_base = cur;
      end
    end else begin
      if (s64) m_rd = cur;
      else if (a % 8 == 0) m_rd = {32'h0, cur[63:32]};
      else m_rd = {32'h0, cur[31:0]};
    end
  endtask

  function automatic string tag_of(bit rq, bit w, logic [4:0] a, bit s64);
    if (!rq) return "R9/R10";
    if (a >= 5'h10) return (a < 5'h18) ? "R7" : "R8";
    if (s64 ? (a[2:0] != 0) : (a[1:0] != 0)) return "R8";
    if (w) return s64 ? "R2" : (a[2] ? "R4" : "R3");
    return s64 ? "R5" : "R6";
  endfunction

  task automatic step(bit rq, bit w, logic [4:0] a, bit s64, logic [63:0] d);
    string t;
    t = tag_of(rq, w, a, s64);
    req_i = rq; we_i = w; addr_i = a; size64_i = s64; wdata_i = d;
    @(posedge clk_i);
    model(rq, w, a, s64, d);
    @(negedge clk_i);
    chk(t, "ctrl_o", ctrl_o, m_ctrl);
    chk(t, "base_o", base_o, m_base);
    chk(t, "rdata_o", rdata_o, m_rd);
    req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk("R1", "ctrl_o", ctrl_o, 64'h0);
    chk("R1", "base_o", base_o, 64'h0);
    chk("R1", "rdata_o", rdata_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1, 0, 5'h00, 1, '0);  // R5: read of reset value

    // R2 full writes, R5 full reads
    step(1, 1, 5'h00, 1, 64'h0123_4567_89AB_CDEF);
    step(1, 1, 5'h08, 1, 64'hFEDC_BA98_7654_3210);
    step(1, 0, 5'h00, 1, '0);
    step(1, 0, 5'h08, 1, '0);
    // R3 upper-half write preserves lower
    step(1, 1, 5'h00, 0, 64'hFFFF_FFFF_AAAA_5555);
    step(1, 1, 5'h08, 0, 64'h0000_0000_1357_9BDF);
    // R4 lower-half write preserves upper
    step(1, 1, 5'h04, 0, 64'h1111_1111_C0DE_F00D);
    step(1, 1, 5'h0C, 0, 64'h0000_0000_2468_ACE0);
    // R6 half reads
    step(1, 0, 5'h00, 0, '0);
    step(1, 0, 5'h04, 0, '0);
    step(1, 0, 5'h08, 0, '0);
    step(1, 0, 5'h0C, 0, '0);
    step(1, 0, 5'h08, 1, '0);
    // R7 flush slots
    step(1, 1, 5'h10, 1, '1);
    step(1, 1, 5'h10, 0, '1);
    step(1, 1, 5'h14, 0, '1);
    step(1, 0, 5'h10, 1, '0);
    step(1, 0, 5'h14, 0, '0);
    // R8 unmapped and misaligned
    step(1, 1, 5'h18, 1, '1);
    step(1, 1, 5'h04, 1, '1);
    step(1, 1, 5'h02, 0, '1);
    step(1, 1, 5'h09, 0, '1);
    step(1, 0, 5'h1C, 0, '0);
    step(1, 0, 5'h0C, 1, '0);
    step(1, 0, 5'h06, 0, '0);
    // R9/R10 idle with busy data
    step(0, 1, 5'h00, 1, 64'hDEAD_BEEF_DEAD_BEEF);
    step(1, 0, 5'h00, 1, '0);
    step(0, 0, 5'h00, 1, '0);
    step(1, 1, 5'h00, 1, 64'h5A5A_5A5A_A5A5_A5A5);

    // mixed random phase
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] d;
      d = {$urandom(), $urandom()};
      step(($urandom() % 5) != 0, $urandom() % 2, 5'($urandom() % 32),
           $urandom() % 2, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule